// File: doc/BRIEF.md
# Symmetric Low-Pass FIR Filter with Folded Taps

This block is a 17-tap low-pass FIR filter that works in signed fixed-point and has a single multiplier. The coefficient set is mirror-symmetric about the centre tap. Before each multiply, the two stored samples that share a coefficient are summed, so one output needs only nine multiply-accumulate steps. Only the nine unique coefficients are held. They are kept as 2.32 constants and rounded to the datapath fraction width when the design is elaborated.

A producer presents a sample on `smp_data` and raises `smp_strobe`. When the controller is idle, the sample is captured on the next clock edge and pushed into the tap history. The filter then runs its calculation. It publishes the new output on `flt_data` together with a one-cycle `flt_strobe` pulse. The output holds its value until the next result is published. Strobes that arrive while a calculation is running have no effect. All arithmetic uses a format with 2 integer bits (sign included) and `FRAC_W` fraction bits. Each step saturates on overflow and rounds half-up when fraction bits are dropped.

Top module: `symfir_lowpass`

## Requirements
- R1: After a synchronous reset, `flt_data` is 0 and `flt_strobe` is 0, and every stored tap is 0.
- R2: Suppose `smp_strobe` is seen high at edge E0 while the filter is idle. Then `smp_data` is captured at edge E1, and `flt_strobe` is high during the cycle after edge E13, so the latency is 13 cycles.
- R3: `flt_strobe` stays high for exactly one cycle per result. `flt_data` changes only at the edge that raises `flt_strobe` and is steady at all other times.
- R4: Take an impulse of value +1.0 (code 0x4000 with the default 14 fraction bits) followed by zeros. The 17 outputs equal the rounded coefficients c0..c16 in order, where c(16-i) = c(i).
- R5: When fraction bits are dropped, the result rounds to the nearest code, and an exact half rounds toward +infinity. An impulse of 0.5 (0x2000) therefore gives floor((c+1)/2) for each rounded coefficient c.
- R6: With a constant input of 0.5, once the history is full the output is within 17 LSB of 0.5 times the sum of all 17 rounded coefficients.
- R7: `smp_strobe` and `smp_data` are ignored while a calculation is in progress. No extra sample enters the history and no extra `flt_strobe` is produced.
- R8: The pre-adder sum of a tap pair saturates to the format limits instead of wrapping. With every tap at -2.0 (0x8000), each pair contributes -2.0 times its coefficient, so the output is -2 times the sum of the nine unique rounded coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_strobe | input | 1 | New sample available (acted on only when idle) |
| smp_data | input | INT_W+FRAC_W | Input sample, signed fixed-point |
| flt_data | output | INT_W+FRAC_W | Filtered output, signed fixed-point, registered |
| flt_strobe | output | 1 | One-cycle pulse marking a new `flt_data` |

## Verification
A fault in the tap history or the pre-adder pairing shows up as a wrong coefficient at a specific position of the impulse response. That error appears at the port within one sample period of the tap being used. A controller that stops one step early or late, or misses the accumulator clear, shows up at the next result. It appears either as a latency other than 13 cycles or as an output polluted by a stale product or sum. A controller that reacts to strobes while busy shifts the history an extra time, which displaces every later impulse-response value. Rounding and saturation faults are visible directly in the output codes of the half-amplitude impulse and the full-scale negative input.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    localparam int TAPS = 17;
    localparam int UNIQ = TAPS / 2 + 1;
    localparam int CW   = 34;
    localparam int CFW  = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CLEAR,
        ST_MAC,
        ST_DRAIN,
        ST_OUT
    } fsm_e;

    // Unique half of the symmetric coefficient set, signed 2.32
    function automatic logic signed [CW-1:0] coef_q32(input int idx);
        case (idx)
            0:       return 34'h0_096FD3CD;
            1:       return 34'h0_0502D771;
            2:       return 34'h3_FA10C582;
            3:       return 34'h3_F0E2F5D9;
            4:       return 34'h3_F36B5FA0;
            5:       return 34'h0_061D65C1;
            6:       return 34'h0_23975445;
            7:       return 34'h0_3E993922;
            8:       return 34'h0_4982ABEC;
            default: return '0;
        endcase
    endfunction

    // Round half-up from 32 fraction bits to fw fraction bits
    function automatic logic signed [CW-1:0] coef_round(input int idx, input int fw);
        logic signed [CW-1:0] c;
        logic signed [CW:0]   raw;
        logic signed [CW:0]   half;
        logic signed [CW:0]   r;
        c    = coef_q32(idx);
        raw  = {c[CW-1], c};
        half = (CW+1)'(1) <<< (CFW - fw - 1);
        r    = raw + half;
        r    = r >>> (CFW - fw);
        return r[CW-1:0];
    endfunction

endpackage

// File: rtl/symfir_taps.sv
module symfir_taps
    import symfir_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    input  logic [AW-1:0]        sel,
    output logic signed [DW-1:0] pair_sum
);

    logic signed [DW-1:0] tap_q  [TAPS];
    logic signed [DW-1:0] tap_d  [TAPS];
    logic signed [DW-1:0] pair_w [UNIQ];

    always_comb begin
        tap_d = tap_q;
        if (shift_en) begin
            tap_d[0] = din;
            for (int i = 1; i < TAPS; i++) begin
                tap_d[i] = tap_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) begin
                tap_q[i] <= '0;
            end
        end else begin
            tap_q <= tap_d;
        end
    end

    // Fold mirrored taps; the centre tap has no partner
    for (genvar k = 0; k < UNIQ; k++) begin : g_pair
        if (k == UNIQ - 1) begin : g_mid
            assign pair_w[k] = tap_q[k];
        end else begin : g_fold
            logic signed [DW:0] wide;
            assign wide = {tap_q[k][DW-1], tap_q[k]}
                        + {tap_q[TAPS-1-k][DW-1], tap_q[TAPS-1-k]};
            assign pair_w[k] = (wide[DW] == wide[DW-1]) ? wide[DW-1:0]
                             : {wide[DW], {(DW-1){~wide[DW]}}};
        end
    end

    assign pair_sum = (int'(sel) < UNIQ) ? pair_w[sel] : '0;

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac
    import symfir_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 14,
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        sel,
    input  logic signed [DW-1:0] pair_sum,
    input  logic                 mul_en,
    input  logic                 acc_clr,
    input  logic                 acc_add,
    output logic signed [DW-1:0] acc
);

    localparam int PW = 2 * DW;

    typedef struct packed {
        logic signed [DW-1:0] prod;
        logic signed [DW-1:0] acc;
    } mac_t;

    mac_t mac_d, mac_q;

    logic signed [DW-1:0] coef_w [UNIQ];
    logic signed [DW-1:0] coef_sel;
    logic signed [PW-1:0] full;
    logic signed [PW:0]   rnd;
    logic signed [PW:0]   sh;
    logic signed [DW-1:0] prod_n;

    for (genvar gi = 0; gi < UNIQ; gi++) begin : g_coef
        localparam logic signed [CW-1:0] CR = coef_round(gi, FW);
        assign coef_w[gi] = CR[DW-1:0];
    end

    function automatic logic signed [DW-1:0] sat_add(input logic signed [DW-1:0] a,
                                                     input logic signed [DW-1:0] b);
        logic signed [DW:0] s;
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] != s[DW-1]) return {s[DW], {(DW-1){~s[DW]}}};
        return s[DW-1:0];
    endfunction

    always_comb begin
        coef_sel = (int'(sel) < UNIQ) ? coef_w[sel] : '0;
        full     = PW'(pair_sum) * PW'(coef_sel);
        rnd      = {full[PW-1], full} + ((PW+1)'(1) <<< (FW - 1));
        sh       = rnd >>> FW;
        if ((&sh[PW:DW-1]) || !(|sh[PW:DW-1])) begin
            prod_n = sh[DW-1:0];
        end else begin
            prod_n = {sh[PW], {(DW-1){~sh[PW]}}};
        end

        mac_d = mac_q;
        if (mul_en) begin
            mac_d.prod = prod_n;
        end
        if (acc_clr) begin
            mac_d.acc = '0;
        end else if (acc_add) begin
            mac_d.acc = sat_add(mac_q.acc, mac_q.prod);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign acc = mac_q.acc;

    // R2: each calculation starts from an empty accumulator
    a_r2_acc_cleared: assert property (@(posedge clk) disable iff (rst)
        acc_clr |=> (mac_q.acc == '0));

    // R4: a clear never coincides with an accumulate request
    a_r4_clr_add_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(acc_clr && acc_add));

endmodule

// File: rtl/symfir_ctrl.sv
module symfir_ctrl
    import symfir_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_strobe,
    output logic          shift_en,
    output logic [AW-1:0] sel,
    output logic          mul_en,
    output logic          acc_clr,
    output logic          acc_add,
    output logic          res_load
);

    localparam logic [AW-1:0] LAST = AW'(UNIQ - 1);

    typedef struct packed {
        fsm_e          st;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        shift_en = 1'b0;
        mul_en   = 1'b0;
        acc_clr  = 1'b0;
        acc_add  = 1'b0;
        res_load = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (smp_strobe) ctl_d.st = ST_SHIFT;
            end
            ST_SHIFT: begin
                shift_en = 1'b1;
                ctl_d.st = ST_CLEAR;
            end
            ST_CLEAR: begin
                acc_clr    = 1'b1;
                ctl_d.addr = '0;
                ctl_d.st   = ST_MAC;
            end
            ST_MAC: begin
                mul_en  = 1'b1;
                acc_add = (ctl_q.addr != '0);
                if (ctl_q.addr == LAST) begin
                    ctl_d.st = ST_DRAIN;
                end else begin
                    ctl_d.addr = ctl_q.addr + 1'b1;
                end
            end
            ST_DRAIN: begin
                acc_add  = 1'b1;
                ctl_d.st = ST_OUT;
            end
            ST_OUT: begin
                res_load = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, addr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sel = ctl_q.addr;

    // R2: history shifts for a single cycle per accepted sample
    a_r2_single_shift: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> !shift_en);

    // R7: no new capture can start while busy
    a_r7_busy_no_capture: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st != ST_IDLE) |=> (ctl_q.st != ST_SHIFT));

    // R4: tap address never leaves the unique-coefficient range
    a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
        ctl_q.addr <= LAST);

    // R2: last tap step is followed by the drain step
    a_r2_drain_follows: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_MAC && ctl_q.addr == LAST) |=> (ctl_q.st == ST_DRAIN));

endmodule

// File: rtl/symfir_lowpass.sv
module symfir_lowpass #(
    parameter int INT_W  = 2,
    parameter int FRAC_W = 14
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          smp_strobe,
    input  logic signed [INT_W+FRAC_W-1:0] smp_data,
    output logic signed [INT_W+FRAC_W-1:0] flt_data,
    output logic                          flt_strobe
);

    localparam int DW = INT_W + FRAC_W;
    localparam int AW = $clog2(symfir_pkg::UNIQ);

    typedef struct packed {
        logic signed [DW-1:0] data;
        logic                 rdy;
    } out_t;

    out_t out_d, out_q;

    logic                 shift_en;
    logic [AW-1:0]        sel;
    logic                 mul_en;
    logic                 acc_clr;
    logic                 acc_add;
    logic                 res_load;
    logic signed [DW-1:0] pair_sum;
    logic signed [DW-1:0] acc;

    symfir_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .smp_strobe(smp_strobe),
        .shift_en  (shift_en),
        .sel       (sel),
        .mul_en    (mul_en),
        .acc_clr   (acc_clr),
        .acc_add   (acc_add),
        .res_load  (res_load)
    );

    symfir_taps #(.DW(DW), .AW(AW)) u_taps (
        .clk     (clk),
        .rst     (rst),
        .shift_en(shift_en),
        .din     (smp_data),
        .sel     (sel),
        .pair_sum(pair_sum)
    );

    symfir_mac #(.DW(DW), .FW(FRAC_W), .AW(AW)) u_mac (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .pair_sum(pair_sum),
        .mul_en  (mul_en),
        .acc_clr (acc_clr),
        .acc_add (acc_add),
        .acc     (acc)
    );

    always_comb begin
        out_d      = out_q;
        out_d.rdy  = res_load;
        if (res_load) out_d.data = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign flt_data   = out_q.data;
    assign flt_strobe = out_q.rdy;

    // R3: result strobe lasts one cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
        flt_strobe |=> !flt_strobe);

    // R3: output only moves together with the strobe
    a_r3_output_hold: assert property (@(posedge clk) disable iff (rst)
        !flt_strobe |-> $stable(flt_data));

endmodule

// File: tb/tb_symfir_lowpass.sv
module tb_symfir_lowpass;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 14;
    localparam int DW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_strobe = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic signed [DW-1:0] flt_data;
    logic                 flt_strobe;

    int n_chk = 0;
    int n_err = 0;
    int cq [17];

    symfir_lowpass #(.INT_W(2), .FRAC_W(FW)) dut (
        .clk       (clk),
        .rst       (rst),
        .smp_strobe(smp_strobe),
        .smp_data  (smp_data),
        .flt_data  (flt_data),
        .flt_strobe(flt_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic real coef_real(input int i);
        case (i)
            0: return 0.0368626;
            1: return 0.019574609;
            2: return -0.023181587;
            3: return -0.05903686;
            4: return -0.04914286;
            5: return 0.02388607;
            6: return 0.13902785;
            7: return 0.2445255;
            default: return 0.28715014;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic signed [DW-1:0] x, input bit disturb, output int y);
        int lat;
        logic signed [DW-1:0] held;
        @(negedge clk);
        smp_data   = x;
        smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
        lat = 0;
        while (!flt_strobe && lat < 60) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 3) begin
                smp_strobe = 1'b1;
                smp_data   = 16'sh2000;
            end
            if (disturb && lat == 6) smp_strobe = 1'b0;
        end
        check(lat == 13, "R2 latency", lat, 13);
        y    = int'(flt_data);
        held = flt_data;
        @(negedge clk);
        check(!flt_strobe, "R3 strobe width", int'(flt_strobe), 0);
        check(flt_data == held, "R3 output hold", int'(flt_data), int'(held));
    endtask

    task automatic flush(input logic signed [DW-1:0] x, output int y);
        for (int i = 0; i < 17; i++) push(x, 1'b0, y);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(flt_data == '0, "R1 reset data", int'(flt_data), 0);
        check(!flt_strobe, "R1 reset strobe", int'(flt_strobe), 0);
    endtask

    task automatic t_impulse(input logic signed [DW-1:0] amp, input real a,
                             input bit disturb, input string req);
        int y;
        int e;
        flush('0, y);
        for (int n = 0; n < 17; n++) begin
            push((n == 0) ? amp : '0, disturb, y);
            e = $rtoi($floor(real'(cq[n]) * a + 0.5));
            check(y == e, req, y, e);
        end
    endtask

    task automatic t_step;
        int y;
        real s;
        int e;
        s = 0.0;
        for (int i = 0; i < 17; i++) s += real'(cq[i]);
        e = $rtoi(0.5 * s);
        flush(16'sh2000, y);
        check((y - e <= 17) && (e - y <= 17), "R6 DC gain", y, e);
    endtask

    task automatic t_sat;
        int y;
        int e;
        e = 0;
        for (int i = 0; i < 9; i++) e += -2 * cq[i];
        flush(16'sh8000, y);
        check(y == e, "R8 pre-add saturation", y, e);
    endtask

    task automatic t_busy;
        int pulses;
        t_impulse(16'sh4000, 1.0, 1'b1, "R7 ignored strobe keeps impulse response");
        pulses = 0;
        repeat (20) begin
            @(negedge clk);
            if (flt_strobe) pulses++;
        end
        check(pulses == 0, "R7 no extra result", pulses, 0);
    endtask

    initial begin
        for (int i = 0; i < 17; i++) begin
            cq[i] = $rtoi($floor(coef_real((i <= 8) ? i : 16 - i) * real'(1 << FW) + 0.5));
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_impulse(16'sh4000, 1.0, 1'b0, "R4 impulse response");
        t_impulse(16'sh2000, 0.5, 1'b0, "R5 half-up rounding");
        t_step();
        t_sat();
        t_busy();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule